// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Upstream Routing

This block gathers 32 level-sensitive interrupt sources and presents them to a primary interrupt controller over 32 upstream lines. Line 31 carries one combined request: the OR of every captured source level that is enabled in a mask register. Sources 21 to 30 can also be routed one for one, each to the upstream line with its own number. These routed lines ignore the mask, so a primary controller can prioritise those sources itself.

Software reaches the block through a plain 32-bit register port. It has a select strobe, a write flag, a word index (byte offset divided by four, across a 4 KB window), write data and read data. A write takes effect on the clock edge where the strobe is high. A read returns data in the same cycle from the current register state. The enable mask has separate set and clear registers, so no read-modify-write is needed. One register pair gives a shortcut to enable bit 0, which serves as a software interrupt. The port has no flow control: it accepts every strobe in the cycle it arrives and never stalls.

Top module: `sec_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every upstream line is low and the level, enable and routing registers read zero.
- R2: Each source is sampled on every clock edge into a level bit. Word index 1 reads all 32 level bits, one per source.
- R3: Upstream line 31 is high exactly when some level bit and the same enable bit are both 1. Word index 0 reads the bitwise AND of level and enable.
- R4: A write to word index 2 ORs the data into the enable mask. A write to index 3 clears the enable bits where the data has ones. A read of index 2 returns the mask.
- R5: A nonzero write to word index 4 sets enable bit 0, and a nonzero write to index 5 clears it. A zero write to either index changes nothing. A read of index 4 returns level bit 0 in bit 0 and zeros in bits 31:1.
- R6: A write to word index 8 ORs into the routing register only data bits 21 to 30 (mask 0x7FE00000). A write to index 9 clears the routing bits where the data has ones. A read of index 8 returns the routing register.
- R7: For each source 21 to 30 whose routing bit is 1, the upstream line with the same number equals that source's level bit. The enable mask has no effect on it.
- R8: Upstream lines 0 to 20 are always low. Lines 21 to 30 whose routing bit is 0 are low.
- R9: Reads of word indices other than 0, 1, 2, 4 and 8 return zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 leave every register unchanged.
- R10: Read data is zero in any cycle without a read strobe (select high, write low). During a read strobe it reflects the register state of that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| irq_up | output | 32 | Lines to the primary controller; 31 combined, 21 to 30 routed |

## Verification
Some rules are checked by assertions on every cycle. The level bits must trail the sources by one edge. The routing register must never hold a bit outside 21 to 30. Unrouted window lines must stay low. The enable set, clear and soft-bit writes must have their effect on the next cycle. Writes to unknown indices must leave state untouched. Reads of unknown indices must return zero. Other behaviour shows only in the bench's scenarios, where a cycle-by-cycle model is compared against the design. This covers how line 31 interacts with the mask and the routing while sources toggle, and what is read back at each index. It also covers that the routed lines ignore the mask, and what comes out of reset.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam int unsigned SIC_LINES = 32;
  localparam int unsigned SIC_IDX_W = 10;

  typedef enum logic [SIC_IDX_W-1:0] {
    IX_PEND       = 10'd0,
    IX_LEVEL      = 10'd1,
    IX_ENABLE     = 10'd2,
    IX_DISABLE    = 10'd3,
    IX_SWI        = 10'd4,
    IX_SWI_CLR    = 10'd5,
    IX_BYPASS     = 10'd8,
    IX_BYPASS_CLR = 10'd9
  } sic_idx_e;

  typedef struct packed {
    logic                  valid;
    logic [SIC_IDX_W-1:0]  idx;
    logic [SIC_LINES-1:0]  data;
  } sic_wr_t;
endpackage

// File: rtl/sic_level_capture.sv
module sic_level_capture #(
  parameter int unsigned N = sec_irq_pkg::SIC_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= irq_in;
  end

  AST_LEVEL_TRAILS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> level_q == $past(irq_in)); // R2
endmodule

// File: rtl/sic_ctrl_regs.sv
module sic_ctrl_regs
  import sec_irq_pkg::*;
#(
  parameter int unsigned N     = SIC_LINES,
  parameter int unsigned WIN_LO = 21,
  parameter int unsigned WIN_HI = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sic_wr_t      wr,
  output logic [N-1:0] en_q,
  output logic [N-1:0] byp_q
);
  function automatic logic [N-1:0] window_mask();
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N); i++)
      if (i >= int'(WIN_LO) && i <= int'(WIN_HI)) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [N-1:0] WIN_MASK = window_mask();

  logic [N-1:0] en_d, byp_d;
  logic         wr_known;

  always_comb begin
    en_d     = en_q;
    byp_d    = byp_q;
    wr_known = 1'b0;
    if (wr.valid) begin
      case (wr.idx)
        IX_ENABLE:     begin en_d = en_q | wr.data;  wr_known = 1'b1; end
        IX_DISABLE:    begin en_d = en_q & ~wr.data; wr_known = 1'b1; end
        IX_SWI:        begin if (|wr.data) en_d[0] = 1'b1; wr_known = 1'b1; end
        IX_SWI_CLR:    begin if (|wr.data) en_d[0] = 1'b0; wr_known = 1'b1; end
        IX_BYPASS:     begin byp_d = byp_q | (wr.data & WIN_MASK); wr_known = 1'b1; end
        IX_BYPASS_CLR: begin byp_d = byp_q & ~wr.data; wr_known = 1'b1; end
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      byp_q <= '0;
    end else begin
      en_q  <= en_d;
      byp_q <= byp_d;
    end
  end

  AST_ENABLE_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.valid && wr.idx == IX_ENABLE) |=> ((en_q & $past(wr.data)) == $past(wr.data))); // R4
  AST_ENABLE_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.valid && wr.idx == IX_DISABLE) |=> ((en_q & $past(wr.data)) == '0)); // R4
  AST_SWI_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.valid && wr.idx == IX_SWI && |wr.data) |=> en_q[0]); // R5
  AST_SWI_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.valid && wr.idx == IX_SWI_CLR && |wr.data) |=> !en_q[0]); // R5
  AST_STRAY_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.valid && !wr_known) |=> ($stable(en_q) && $stable(byp_q))); // R9
endmodule

// File: rtl/sic_out_route.sv
module sic_out_route #(
  parameter int unsigned N      = sec_irq_pkg::SIC_LINES,
  parameter int unsigned WIN_LO = 21,
  parameter int unsigned WIN_HI = 30,
  parameter int unsigned COMB   = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_q,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] byp_q,
  output logic [N-1:0] irq_up
);
  logic any_pending;
  assign any_pending = |(level_q & en_q);

  for (genvar i = 0; i < int'(N); i++) begin : g_line
    if (i == int'(COMB)) begin : g_comb
      assign irq_up[i] = any_pending;
    end else if (i >= int'(WIN_LO) && i <= int'(WIN_HI)) begin : g_route
      assign irq_up[i] = level_q[i] & byp_q[i];
    end else begin : g_quiet
      assign irq_up[i] = 1'b0;
    end
  end

  AST_ROUTE_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q[WIN_LO-1:0] == '0) && (byp_q[N-1:WIN_HI+1] == '0)); // R6
  AST_UNROUTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_up[WIN_HI:WIN_LO] & ~byp_q[WIN_HI:WIN_LO]) == '0); // R8
endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
  import sec_irq_pkg::*;
#(
  parameter int unsigned N     = SIC_LINES,
  parameter int unsigned IDX_W = SIC_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [N-1:0]     level_q,
  input  logic [N-1:0]     en_q,
  input  logic [N-1:0]     byp_q,
  output logic [N-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (rd_idx)
        IX_PEND:   rdata = level_q & en_q;
        IX_LEVEL:  rdata = level_q;
        IX_ENABLE: rdata = en_q;
        IX_SWI:    rdata = {{(N-1){1'b0}}, level_q[0]};
        IX_BYPASS: rdata = byp_q;
        default:   rdata = '0;
      endcase
    end
  end

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(rd_idx inside {IX_PEND, IX_LEVEL, IX_ENABLE, IX_SWI, IX_BYPASS})) |-> rdata == '0); // R9
  AST_SWI_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == IX_SWI) |-> rdata[N-1:1] == '0); // R5
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sec_irq_pkg::*;
#(
  parameter int unsigned N      = SIC_LINES,
  parameter int unsigned IDX_W  = SIC_IDX_W,
  parameter int unsigned WIN_LO = 21,
  parameter int unsigned WIN_HI = 30,
  parameter int unsigned COMB   = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [N-1:0]     bus_wdata,
  output logic [N-1:0]     bus_rdata,
  input  logic [N-1:0]     irq_in,
  output logic [N-1:0]     irq_up
);
  logic [N-1:0] level_q, en_q, byp_q;
  sic_wr_t      wr;

  assign wr.valid = bus_sel & bus_we;
  assign wr.idx   = bus_addr;
  assign wr.data  = bus_wdata;

  sic_level_capture #(.N(N)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_q(level_q)
  );

  sic_ctrl_regs #(.N(N), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .en_q(en_q), .byp_q(byp_q)
  );

  sic_out_route #(.N(N), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .COMB(COMB)) u_route (
    .clk(clk), .rst_n(rst_n), .level_q(level_q), .en_q(en_q), .byp_q(byp_q),
    .irq_up(irq_up)
  );

  sic_read_mux #(.N(N), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_sel & ~bus_we), .rd_idx(bus_addr),
    .level_q(level_q), .en_q(en_q), .byp_q(byp_q), .rdata(bus_rdata)
  );

  AST_COMB_FALLS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_up[COMB] && en_q == '0) |-> 1'b0); // R3
endmodule

// File: tb/test_sec_irq_ctrl.sv
module test_sec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_in = '0, irq_up;
  int          total = 0, bad = 0;
  bit          done = 1'b0;
  logic [31:0] m_lvl, m_en, m_byp;
  logic [31:0] seed = 32'h1234_5679;

  always #10 clk = ~clk;

  sec_irq_ctrl i_sec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_up(irq_up)
  );

  // behavioural reference, one update per edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl <= '0; m_en <= '0; m_byp <= '0;
    end else begin
      m_lvl <= irq_in;
      if (bus_sel && bus_we) begin
        case (int'(bus_addr))
          2: m_en  <= m_en | bus_wdata;
          3: m_en  <= m_en & ~bus_wdata;
          4: if (bus_wdata != 0) m_en[0] <= 1'b1;
          5: if (bus_wdata != 0) m_en[0] <= 1'b0;
          8: m_byp <= m_byp | (bus_wdata & 32'h7FE0_0000);
          9: m_byp <= m_byp & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd_model(int idx);
    case (idx)
      0: return m_lvl & m_en;
      1: return m_lvl;
      2: return m_en;
      4: return {31'b0, m_lvl[0]};
      8: return m_byp;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(int idx);
    case (idx)
      0: return "R3 pending read";
      1: return "R2 level read";
      2: return "R4 enable read";
      4: return "R5 soft read";
      8: return "R6 routing read";
      default: return "R9 stray read";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 lines in reset", irq_up, 32'h0);
    end else if (!done) begin
      chk("R3 combined line", {31'b0, irq_up[31]}, {31'b0, |(m_lvl & m_en)});
      chk("R7 routed lines", {22'b0, irq_up[30:21]}, {22'b0, m_lvl[30:21] & m_byp[30:21]});
      chk("R8 quiet lines", {11'b0, irq_up[20:0]}, 32'h0);
      if (bus_sel && !bus_we) chk(rd_tag(int'(bus_addr)), bus_rdata, rd_model(int'(bus_addr)));
      else                    chk("R10 idle read data", bus_rdata, 32'h0);
    end
  end

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 10'(idx); bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int idx);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 10'(idx);
    step();
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 read in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    rd(1); rd(2); rd(8);                      // R1 state after reset
    irq_in = 32'hA5A5_0F0F; step(); rd(1);    // R2
    wr(2, 32'h0000_00F0); rd(2); rd(0);       // R4 R3
    wr(3, 32'h0000_0030); rd(2); rd(0);
    irq_in = 32'h0; step(); step();           // R3 line falls
    wr(4, 32'h0); rd(2);                      // R5 zero write inert
    irq_in = 32'h1; wr(4, 32'h5); rd(4); rd(0);
    wr(5, 32'h0); rd(2); wr(5, 32'h1); rd(2);
    irq_in = 32'hFFFF_FFFF;
    wr(8, 32'hFFFF_FFFF); rd(8);              // R6 window only
    wr(3, 32'hFFFF_FFFF); step(); step();     // R7 mask has no say
    wr(9, 32'h0060_0000); rd(8); step();      // R8 unrouted low
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF); wr(1023, 32'hFFFF_FFFF);
    rd(2); rd(8); rd(3); rd(5); rd(9); rd(6); rd(12); rd(1023); // R9
    for (int k = 0; k < 600; k++) begin
      seed = nxt(seed);
      irq_in = seed;
      seed = nxt(seed);
      case (seed[1:0])
        2'd0: step();
        2'd1: wr(int'(seed[5:2]) % 12, (seed[9:6] == 0) ? 32'h0 : nxt(seed));
        default: rd(int'(seed[5:2]) % 12);
      endcase
    end
    step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule